// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block drives an eight-channel, ten-bit converter from a plain register port. Software writes one command word that chooses the channel, how many conversions to average, the reference and the enable, and sets a start flag in the same word. The block makes the converter clock from the bus clock with separately programmed high and low phase lengths. It asks for one sample on each rising converter clock edge and adds up the requested power-of-two number of samples. It then divides the sum by shifting, stores the mean and raises an interrupt. Reading the result register drops the interrupt.

The converter is modelled as a sample port. A one-cycle request goes out and the block waits for a valid pulse carrying ten bits. Each channel has one control register and one result register. A 32-bit scan rate is split over two 16-bit registers. The control and scan-rate registers are storage only. Writing a command word with the enable bit clear stops any sequence and leaves the block idle and disabled.

The sequencer has four states. IDLE goes to ARM on an accepted start. ARM goes to WAIT in the cycle before the converter clock rises, and the request pulse is issued in that cycle. WAIT goes back to ARM when a valid arrives and more samples are due. WAIT goes to DONE when the last sample arrives. DONE always returns to IDLE. A disabling command write moves any state to IDLE.

Top module: `adc_ctrl_top`

## Requirements
- R1: After reset every register reads zero, and irq, adc_clk, adc_en and sample_req are low.
- R2: The command register at address 0x00 has these fields: bit 0 start, bits 3:1 channel, bit 4 enable, bits 8:5 averaging exponent N, bit 9 internal reference. A read returns the stored fields with bit 0 always 0. The fields drive adc_chan, adc_en and adc_vref_int.
- R3: The clock register at address 0x01 holds the low count in bits 3:0 and the high count in bits 7:4. While enabled, adc_clk is high for the high count and has a period equal to the sum of the two counts, in bus cycles. adc_clk stays low while adc_en is low.
- R4: sample_req is a one-cycle pulse that is issued only while a sequence runs and adc_en is high. adc_clk is low in the pulse cycle and rises in the next cycle.
- R5: A sequence takes 2^N samples and returns their sum shifted right by N. N=0 gives a single conversion.
- R6: irq rises two cycles after the valid that carries the last sample. A read of address 0x02 returns the result in bits 9:0 with bits 31:10 at zero, and clears irq at the following edge.
- R7: When a sequence ends, the result is also stored in the channel data register at 0x10+channel. Reading that register leaves irq unchanged.
- R8: A command with the start bit set and the enable bit clear starts nothing.
- R9: While a sequence runs, a command write with the enable bit set is ignored completely: the channel and the sequence do not change.
- R10: A command write with the enable bit clear stops a running sequence. No further request follows and irq stays low. A later start works normally.
- R11: The channel control registers at 0x08+c and the scan-rate registers at 0x03 (low half) and 0x04 (high half) are each 16 bits, read and write. Their upper bits read as zero.
- R12: A high or low count of zero counts as one cycle, so the period is never shorter than two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| irq | output | 1 | Sequence complete interrupt |
| adc_clk | output | 1 | Generated converter clock |
| adc_en | output | 1 | Converter enable |
| adc_vref_int | output | 1 | Internal reference select |
| adc_chan | output | 3 | Selected channel |
| sample_req | output | 1 | Sample request pulse |
| sample_valid | input | 1 | Sample valid pulse |
| sample_data | input | 10 | Sample value |

## Verification
A wrong sample count or a wrong shift shows up as a wrong result word and as an interrupt at the wrong time. The bench predicts irq on every clock, so an early or late completion is caught within one cycle of the final valid. A state machine stuck in a busy state after an abort shows up as extra request pulses or an unexpected interrupt within a few converter clock periods. Phase counter faults change the measured high time and period on the next converter clock cycle.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ARM,
        S_WAIT,
        S_DONE
    } seq_state_t;

    localparam logic [4:0] A_CMD  = 5'h00;
    localparam logic [4:0] A_CLK  = 5'h01;
    localparam logic [4:0] A_RES  = 5'h02;
    localparam logic [4:0] A_SCLO = 5'h03;
    localparam logic [4:0] A_SCHI = 5'h04;

endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen #(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [PH_W-1:0] lo_cnt,
    input  logic [PH_W-1:0] hi_cnt,
    output logic            conv_clk,
    output logic            rise_next
);
    logic [PH_W-1:0] lo_len, hi_len, cur_len, cnt;
    logic            ph;

    always_comb begin
        lo_len  = (lo_cnt == '0) ? PH_W'(1) : lo_cnt;
        hi_len  = (hi_cnt == '0) ? PH_W'(1) : hi_cnt;
        cur_len = ph ? hi_len : lo_len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph  <= 1'b0;
            cnt <= PH_W'(1);
        end else if (!en) begin
            ph  <= 1'b0;
            cnt <= PH_W'(1);
        end else if (cnt >= cur_len) begin
            ph  <= ~ph;
            cnt <= PH_W'(1);
        end else begin
            cnt <= cnt + PH_W'(1);
        end
    end

    assign conv_clk  = ph && en;
    assign rise_next = en && !ph && (cnt >= lo_len);
endmodule

// File: rtl/adc_avg_seq.sv
module adc_avg_seq
    import adc_ctrl_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int AVG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              abort,
    input  logic [AVG_W-1:0]  depth,
    input  logic              rise_next,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              smp_req,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    localparam int MAX_LOG = (1 << AVG_W) - 1;
    localparam int ACC_W   = DATA_W + MAX_LOG;
    localparam int CNT_W   = MAX_LOG + 1;

    seq_state_t       state, state_nx;
    logic [ACC_W-1:0] acc;
    logic [CNT_W-1:0] cnt;
    logic [AVG_W-1:0] n_q;
    logic             last;

    assign last = (cnt == ((CNT_W'(1) << n_q) - CNT_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (abort) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: if (go)        state_nx = S_ARM;
                S_ARM:  if (rise_next) state_nx = S_WAIT;
                S_WAIT: if (smp_valid) state_nx = last ? S_DONE : S_ARM;
                S_DONE: state_nx = S_IDLE;
            endcase
        end
    end

    always_comb begin
        smp_req = (state == S_ARM) && rise_next && !abort;
        busy    = (state != S_IDLE);
        done    = (state == S_DONE) && !abort;
        result  = DATA_W'(acc >> n_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            cnt <= '0;
            n_q <= '0;
        end else if (state == S_IDLE && go) begin
            acc <= '0;
            cnt <= '0;
            n_q <= depth;
        end else if (state == S_WAIT && smp_valid) begin
            acc <= acc + ACC_W'(smp_data);
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/adc_ctrl_top.sv
module adc_ctrl_top
    import adc_ctrl_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int DATA_W  = 10,
    parameter int AVG_W   = 4,
    parameter int PH_W    = 4,
    parameter int HALF_W  = 16,
    parameter int ADDR_W  = 5,
    parameter int BUS_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [BUS_W-1:0]         reg_wdata,
    output logic [BUS_W-1:0]         reg_rdata,
    output logic                     irq,
    output logic                     adc_clk,
    output logic                     adc_en,
    output logic                     adc_vref_int,
    output logic [$clog2(NCH)-1:0]   adc_chan,
    output logic                     sample_req,
    input  logic                     sample_valid,
    input  logic [DATA_W-1:0]        sample_data
);
    localparam int CH_W     = $clog2(NCH);
    localparam int EN_BIT   = 1 + CH_W;
    localparam int AVG_LSB  = EN_BIT + 1;
    localparam int VREF_BIT = AVG_LSB + AVG_W;
    localparam logic [ADDR_W-CH_W-1:0] RG_CTL = 1;
    localparam logic [ADDR_W-CH_W-1:0] RG_DAT = 2;

    logic [CH_W-1:0]   cmd_chan;
    logic              cmd_en, cmd_vref;
    logic [AVG_W-1:0]  cmd_avg;
    logic [PH_W-1:0]   clk_lo, clk_hi;
    logic [HALF_W-1:0] scan_lo, scan_hi;
    logic [HALF_W-1:0] ch_ctl [NCH];
    logic [DATA_W-1:0] ch_dat [NCH];
    logic [DATA_W-1:0] res_q, seq_res;
    logic              irq_q;
    logic              busy, done, go, abort, cmd_wr, rise_next;
    logic [CH_W-1:0]   idx;
    logic [ADDR_W-CH_W-1:0] region;

    assign idx    = reg_addr[CH_W-1:0];
    assign region = reg_addr[ADDR_W-1:CH_W];
    assign cmd_wr = reg_wr && (reg_addr == A_CMD);
    assign abort  = cmd_wr && !reg_wdata[EN_BIT] && busy;
    assign go     = cmd_wr && !busy && reg_wdata[0] && reg_wdata[EN_BIT];

    adc_clk_gen #(.PH_W(PH_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(cmd_en), .lo_cnt(clk_lo), .hi_cnt(clk_hi),
        .conv_clk(adc_clk), .rise_next(rise_next)
    );

    adc_avg_seq #(.DATA_W(DATA_W), .AVG_W(AVG_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .depth(reg_wdata[AVG_LSB +: AVG_W]),
        .rise_next(rise_next), .smp_valid(sample_valid), .smp_data(sample_data),
        .smp_req(sample_req), .busy(busy), .done(done), .result(seq_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_chan <= '0; cmd_en <= 1'b0; cmd_avg <= '0; cmd_vref <= 1'b0;
            clk_lo <= '0; clk_hi <= '0; scan_lo <= '0; scan_hi <= '0;
            res_q <= '0; irq_q <= 1'b0;
            for (int i = 0; i < NCH; i++) begin
                ch_ctl[i] <= '0;
                ch_dat[i] <= '0;
            end
        end else begin
            if (cmd_wr && !(busy && reg_wdata[EN_BIT])) begin
                cmd_chan <= reg_wdata[CH_W:1];
                cmd_en   <= reg_wdata[EN_BIT];
                cmd_avg  <= reg_wdata[AVG_LSB +: AVG_W];
                cmd_vref <= reg_wdata[VREF_BIT];
            end
            if (reg_wr && reg_addr == A_CLK) begin
                clk_lo <= reg_wdata[PH_W-1:0];
                clk_hi <= reg_wdata[2*PH_W-1:PH_W];
            end
            if (reg_wr && reg_addr == A_SCLO) scan_lo <= reg_wdata[HALF_W-1:0];
            if (reg_wr && reg_addr == A_SCHI) scan_hi <= reg_wdata[HALF_W-1:0];
            if (reg_wr && region == RG_CTL) ch_ctl[idx] <= reg_wdata[HALF_W-1:0];
            if (done) begin
                res_q            <= seq_res;
                ch_dat[cmd_chan] <= seq_res;
                irq_q            <= 1'b1;
            end else if (reg_rd && reg_addr == A_RES) begin
                irq_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CMD) begin
            reg_rdata[CH_W:1]               = cmd_chan;
            reg_rdata[EN_BIT]               = cmd_en;
            reg_rdata[AVG_LSB +: AVG_W]     = cmd_avg;
            reg_rdata[VREF_BIT]             = cmd_vref;
        end else if (reg_addr == A_CLK) begin
            reg_rdata[2*PH_W-1:0] = {clk_hi, clk_lo};
        end else if (reg_addr == A_RES) begin
            reg_rdata[DATA_W-1:0] = res_q;
        end else if (reg_addr == A_SCLO) begin
            reg_rdata[HALF_W-1:0] = scan_lo;
        end else if (reg_addr == A_SCHI) begin
            reg_rdata[HALF_W-1:0] = scan_hi;
        end else if (region == RG_CTL) begin
            reg_rdata[HALF_W-1:0] = ch_ctl[idx];
        end else if (region == RG_DAT) begin
            reg_rdata[DATA_W-1:0] = ch_dat[idx];
        end
    end

    assign irq          = irq_q;
    assign adc_en       = cmd_en;
    assign adc_vref_int = cmd_vref;
    assign adc_chan     = cmd_chan;
endmodule

// File: rtl/adc_ctrl_checker.sv
module adc_ctrl_checker #(
    parameter int PH_W   = 4,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              sample_req,
    input logic              sample_valid,
    input logic              adc_clk,
    input logic              adc_en,
    input logic              irq,
    input logic              seq_done
);
    logic [PH_W:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run <= '0;
        else if (adc_clk) run <= run + 1'b1;
        else              run <= '0;
    end

    AST_HIGH_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        adc_clk |-> (run < (PH_W+1)'(1 << PH_W))); // R3
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |-> adc_en); // R4
    AST_REQ_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |-> !adc_clk); // R4
    AST_REQ_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_req && !(reg_wr && reg_addr == '0)) |=> adc_clk); // R4
    AST_IRQ_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(sample_valid, 2)); // R6
    AST_IRQ_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(seq_done)); // R6
    AST_IRQ_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 5'h02 && !seq_done) |=> !irq); // R6
endmodule

bind adc_ctrl_top adc_ctrl_checker #(.PH_W(PH_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .sample_req(sample_req), .sample_valid(sample_valid), .adc_clk(adc_clk),
    .adc_en(adc_en), .irq(irq), .seq_done(done)
);

// File: tb/tb_adc_ctrl_top.sv
`timescale 1ns/1ps
module tb_adc_ctrl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq, adc_clk, adc_en, adc_vref_int, sample_req;
    logic [2:0]  adc_chan;
    logic        sample_valid = 1'b0;
    logic [9:0]  sample_data = '0;

    int n_chk = 0, n_fail = 0;
    int n_req = 0, remain = 0, lat = 3, lat_cnt = 0, cd = 0;
    bit irq_exp = 0, clr_pend = 0, model_on = 0, cancel = 0, prev_req = 0;
    int q[$];

    always #5 clk = ~clk;

    adc_ctrl_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .adc_clk(adc_clk),
        .adc_en(adc_en), .adc_vref_int(adc_vref_int), .adc_chan(adc_chan),
        .sample_req(sample_req), .sample_valid(sample_valid), .sample_data(sample_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        if (a == 5'h02) clr_pend = 1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic measure(output int per, output int hi);
        logic prev;
        do begin prev = adc_clk; @(negedge clk); end while (!(!prev && adc_clk));
        per = 0; hi = 0;
        do begin
            if (adc_clk) hi++;
            per++;
            prev = adc_clk;
            @(negedge clk);
        end while (!(!prev && adc_clk));
    endtask

    task automatic wait_irq();
        while (!irq_exp) @(negedge clk);
    endtask

    // converter model: answers each request after a latency
    always @(negedge clk) begin
        sample_valid = 1'b0;
        if (prev_req) chk("R4 adc_clk rises after request", adc_clk, 1'b1);
        prev_req = sample_req;
        if (cancel) begin lat_cnt = 0; cancel = 0; end
        if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0 && q.size() > 0) begin
                sample_valid = 1'b1;
                sample_data  = 10'(q.pop_front());
                remain--;
                if (remain == 0) cd = 2;
            end
        end
        if (sample_req) begin
            lat_cnt = lat;
            n_req++;
        end
    end

    // per-cycle reference of irq and clock gating
    always @(posedge clk) begin
        #1;
        if (model_on) begin
            if (cd > 0) begin cd--; if (cd == 0) irq_exp = 1; end
            if (clr_pend) begin irq_exp = 0; clr_pend = 0; end
            chk("R6 irq per cycle", irq, irq_exp);
            if (!adc_en) chk("R3 adc_clk low when disabled", adc_clk, 1'b0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int per, hi, base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1;
        // R1 reset state
        chk("R1 irq", irq, 0); chk("R1 adc_clk", adc_clk, 0);
        chk("R1 adc_en", adc_en, 0); chk("R1 sample_req", sample_req, 0);
        rd_chk(5'h00, 0, "R1 cmd"); rd_chk(5'h01, 0, "R1 clk");
        rd_chk(5'h02, 0, "R1 result"); rd_chk(5'h03, 0, "R1 scan lo");
        rd_chk(5'h04, 0, "R1 scan hi"); rd_chk(5'h0B, 0, "R1 ch ctl");
        rd_chk(5'h15, 0, "R1 ch data");
        // R11 storage registers
        wr(5'h03, 32'hABCD1234); rd_chk(5'h03, 32'h1234, "R11 scan lo");
        wr(5'h04, 32'hFFFF5678); rd_chk(5'h04, 32'h5678, "R11 scan hi");
        wr(5'h0B, 32'h00012345); rd_chk(5'h0B, 32'h2345, "R11 ch ctl 3");
        rd_chk(5'h0C, 0, "R11 ch ctl 4 untouched");
        // R2 field readback without start
        wr(5'h00, 32'h3FE); rd_chk(5'h00, 32'h3FE, "R2 cmd readback");
        chk("R2 adc_chan", adc_chan, 3'd7); chk("R2 adc_vref_int", adc_vref_int, 1);
        chk("R2 adc_en", adc_en, 1);
        // R3 / R12 clock shape
        wr(5'h01, 32'h32); rd_chk(5'h01, 32'h32, "R3 clk readback");
        measure(per, hi); chk("R3 period 3+2", per, 5); chk("R3 high 3", hi, 3);
        wr(5'h01, 32'h00);
        measure(per, hi); chk("R12 period zero counts", per, 2); chk("R12 high zero", hi, 1);
        wr(5'h01, 32'h50);
        measure(per, hi); chk("R12 period hi5 lo0", per, 6); chk("R12 high 5", hi, 5);
        wr(5'h00, 32'h0);
        // R5 N=0 single conversion on channel 2
        wr(5'h01, 32'h11);
        q.push_back(517); remain = 1; base = n_req;
        wr(5'h00, 32'h15);
        wait_irq();
        chk("R5 one request for N=0", n_req - base, 1);
        rd_chk(5'h00, 32'h14, "R2 start bit reads zero");
        rd_chk(5'h12, 517, "R7 channel data 2");
        chk("R7 irq kept after data read", irq, 1);
        rd_chk(5'h02, 517, "R6 result N=0");
        @(negedge clk); chk("R6 irq cleared", irq, 0);
        // R5 N=2 on channel 5, with a start while busy (R9)
        q.push_back(100); q.push_back(200); q.push_back(301); q.push_back(400);
        remain = 4; base = n_req;
        wr(5'h00, 32'h5B);
        while (n_req == base) @(negedge clk);
        wr(5'h00, 32'h13);
        chk("R9 channel unchanged while busy", adc_chan, 3'd5);
        wait_irq();
        chk("R5 four requests for N=2", n_req - base, 4);
        rd_chk(5'h15, 250, "R7 channel data 5");
        rd_chk(5'h02, 250, "R5 average N=2");
        rd_chk(5'h00, 32'h5A, "R9 command kept");
        // R5 N=3 full-scale on channel 0, fastest clock
        wr(5'h01, 32'h00);
        for (int i = 0; i < 8; i++) q.push_back(1023);
        remain = 8; base = n_req;
        wr(5'h00, 32'h71);
        wait_irq();
        chk("R5 eight requests for N=3", n_req - base, 8);
        rd_chk(5'h02, 1023, "R5 full-scale average");
        rd_chk(5'h10, 1023, "R7 channel data 0");
        // R8 start with enable clear
        wr(5'h00, 32'h0); base = n_req;
        wr(5'h00, 32'h07);
        repeat (40) @(negedge clk);
        chk("R8 no request", n_req - base, 0);
        rd_chk(5'h00, 32'h06, "R8 enable stays low");
        // R10 abort mid-sequence
        wr(5'h01, 32'h22); lat = 20;
        for (int i = 0; i < 4; i++) q.push_back(50);
        remain = 4; base = n_req;
        wr(5'h00, 32'h5D);
        while (n_req == base) @(negedge clk);
        wr(5'h00, 32'h0);
        cancel = 1;
        chk("R10 adc_en low after abort", adc_en, 0);
        repeat (60) @(negedge clk);
        chk("R10 no request after abort", n_req - base, 1);
        chk("R10 irq low after abort", irq, 0);
        q.delete(); lat = 3;
        q.push_back(77); remain = 1; base = n_req;
        wr(5'h00, 32'h1D);
        wait_irq();
        rd_chk(5'h02, 77, "R10 restart result");
        rd_chk(5'h16, 77, "R7 channel data 6");
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule